// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word addresses of a four-beat cache-line burst for a synchronous pipelined SRAM. A burst begins when either of two address strobes is seen at a rising clock edge. One strobe comes from the processor and the other from the cache controller. At that edge the external word address is loaded. The upper bits are held as the line address. The two low bits give the first beat. Later beats are generated inside the block, and each one moves forward only on an edge where the advance input is high.

A static order input picks one of two beat orders. Linear order adds the beat count to the starting low bits. Interleaved order XORs them. The count wraps inside the same four-word line, so the line address never changes during a burst. A chip-select input, when high, masks the processor strobe. The controller strobe is never masked. If both strobes start a burst on the same edge, the processor strobe wins, and an output records which strobe began the current burst.

All outputs are registered and change only on the rising clock edge that follows the inputs that cause the change. Reset is synchronous and active high.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high at a clock edge, after that edge line_addr, beat_addr, beat_valid and start_src are all 0.
- R2: A clock edge with proc_strobe high and cs_block low loads the address. After it, line_addr equals addr_in[ADDR_W-1:2], beat_addr equals addr_in[1:0], beat_valid is 1 and start_src is 0.
- R3: A clock edge with ctrl_strobe high loads the address in the same way whatever the level of cs_block. After it start_src is 1, unless R5 applies.
- R4: A clock edge with proc_strobe high, cs_block high and ctrl_strobe low changes no output.
- R5: When proc_strobe and ctrl_strobe are both high and cs_block is low, the processor strobe wins and start_src is 0 after the edge.
- R6: With interleave_mode at 0 (linear), beat k of a burst that starts at low bits s has beat_addr equal to (s + k) mod 4.
- R7: With interleave_mode at 1 (interleaved), beat k of a burst that starts at low bits s has beat_addr equal to s XOR k.
- R8: An edge with no strobe in effect and adv low leaves beat_addr and line_addr unchanged and uses up no beat. The next advance gives the next beat in order.
- R9: The advance after the fourth beat brings beat_addr back to the starting low bits, and line_addr does not change.
- R10: A strobe during a burst starts a new burst with the count reset to beat 0. This also holds on an edge where adv is high.
- R11: Before any burst has started after reset, adv has no effect: beat_addr stays 0 and beat_valid stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_strobe | input | 1 | Processor address strobe, active high |
| ctrl_strobe | input | 1 | Cache-controller address strobe, active high |
| cs_block | input | 1 | When high, masks proc_strobe |
| adv | input | 1 | Advance to the next beat |
| interleave_mode | input | 1 | Beat order: 0 is linear, 1 is interleaved |
| addr_in | input | ADDR_W | External word address |
| line_addr | output | ADDR_W-2 | Registered line address |
| beat_addr | output | 2 | Low address bits of the current beat |
| beat_valid | output | 1 | High once a burst has been started |
| start_src | output | 1 | Strobe that began the burst: 0 is processor, 1 is controller |

## Verification
A wrong beat count shows on beat_addr on the first advance edge after the error. It then stays wrong for every later beat, and on the wrap it does not come back to the start. A stale starting value or a wrong order shows within one advance. A fault in strobe masking or priority shows on line_addr or start_src at the edge right after the strobe. A counter that moves while adv is low shows on the next advance, because one beat is skipped. Because of this, every burst is walked through all four beats and the wrap, in both orders, with and without hold cycles.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } beat_order_e;

  typedef enum logic {
    SRC_PROC = 1'b0,
    SRC_CTRL = 1'b1
  } start_src_e;
endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
  import burst_seq_pkg::*;
(
  input  logic       proc_strobe,
  input  logic       ctrl_strobe,
  input  logic       cs_block,
  output logic       start,
  output start_src_e src
);
  logic proc_ok;

  always_comb begin
    proc_ok = proc_strobe & ~cs_block;
    start   = proc_ok | ctrl_strobe;
    src     = proc_ok ? SRC_PROC : SRC_CTRL;
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step,
  output logic [BEAT_W-1:0] count,
  output logic [BEAT_W-1:0] count_next
);
  always_comb begin
    if (start)
      count_next = '0;
    else if (step)
      count_next = count + 1'b1;
    else
      count_next = count;
  end

  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else
      count <= count_next;
  end

  // R10: a strobe puts the count back at beat 0
  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> (count == '0));

  // R8: the count holds when there is no step and no start
  p_hold_count_r8: assert property (@(posedge clk) disable iff (rst)
    (!start && !step) |=> $stable(count));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     proc_strobe,
  input  logic                     ctrl_strobe,
  input  logic                     cs_block,
  input  logic                     adv,
  input  logic                     interleave_mode,
  input  logic [ADDR_W-1:0]        addr_in,
  output logic [ADDR_W-BEAT_W-1:0] line_addr,
  output logic [BEAT_W-1:0]        beat_addr,
  output logic                     beat_valid,
  output logic                     start_src
);
  localparam int LINE_W = ADDR_W - BEAT_W;

  logic              start;
  start_src_e        src;
  logic              step;
  logic [BEAT_W-1:0] count;
  logic [BEAT_W-1:0] count_next;
  logic [BEAT_W-1:0] start_lo;
  logic [BEAT_W-1:0] next_beat;
  beat_order_e       order;

  strobe_arbiter u_arb (
    .proc_strobe (proc_strobe),
    .ctrl_strobe (ctrl_strobe),
    .cs_block    (cs_block),
    .start       (start),
    .src         (src)
  );

  assign step = adv & beat_valid;

  beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .step       (step),
    .count      (count),
    .count_next (count_next)
  );

  always_comb begin
    order = beat_order_e'(interleave_mode);
    if (order == ORDER_INTERLEAVE)
      next_beat = start_lo ^ count_next;
    else
      next_beat = start_lo + count_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_addr  <= '0;
      beat_addr  <= '0;
      start_lo   <= '0;
      beat_valid <= 1'b0;
      start_src  <= 1'b0;
    end else if (start) begin
      line_addr  <= addr_in[ADDR_W-1:BEAT_W];
      beat_addr  <= addr_in[BEAT_W-1:0];
      start_lo   <= addr_in[BEAT_W-1:0];
      beat_valid <= 1'b1;
      start_src  <= src;
    end else if (step) begin
      beat_addr  <= next_beat;
    end
  end

  // R1: reset clears the outputs
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!beat_valid && beat_addr == '0 && line_addr == '0 && !start_src));

  // R2: a processor strobe that is not masked loads the address
  p_proc_load_r2: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe && !cs_block) |=>
      (line_addr == $past(addr_in[ADDR_W-1:BEAT_W]) &&
       beat_addr == $past(addr_in[BEAT_W-1:0]) && beat_valid && !start_src));

  // R3: the controller strobe loads even while cs_block is high
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_strobe && !(proc_strobe && !cs_block)) |=>
      (line_addr == $past(addr_in[ADDR_W-1:BEAT_W]) && start_src));

  // R4: a masked processor strobe changes nothing
  p_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (proc_strobe && cs_block && !ctrl_strobe && !adv) |=>
      ($stable(line_addr) && $stable(beat_addr) && $stable(start_src) &&
       $stable(beat_valid)));

  // R6: in linear order each advance moves one step up
  p_linear_step_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && beat_valid && !interleave_mode && !ctrl_strobe &&
     !(proc_strobe && !cs_block)) |=>
      (beat_addr == $past(beat_addr) + 1'b1));

  // R8: with no strobe and no advance the address holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!adv && !ctrl_strobe && !(proc_strobe && !cs_block)) |=>
      ($stable(beat_addr) && $stable(line_addr)));

  // R9: advancing never touches the line address
  p_line_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_strobe && !(proc_strobe && !cs_block)) |=> $stable(line_addr));

  // R11: once valid, the burst stays valid until reset
  p_valid_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    beat_valid |=> beat_valid);
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int ADDR_W = 18;
  localparam int LINE_W = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              proc_strobe, ctrl_strobe, cs_block, adv, interleave_mode;
  logic [ADDR_W-1:0] addr_in;
  logic [LINE_W-1:0] line_addr;
  logic [1:0]        beat_addr;
  logic              beat_valid, start_src;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) uut (
    .clk(clk), .rst(rst), .proc_strobe(proc_strobe), .ctrl_strobe(ctrl_strobe),
    .cs_block(cs_block), .adv(adv), .interleave_mode(interleave_mode),
    .addr_in(addr_in), .line_addr(line_addr), .beat_addr(beat_addr),
    .beat_valid(beat_valid), .start_src(start_src)
  );

  task automatic chk(string req, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [1:0] expect_beat(logic [1:0] s, int k, bit il);
    return il ? (s ^ 2'(k)) : (s + 2'(k));
  endfunction

  task automatic load(bit p, bit c, bit cs, logic [ADDR_W-1:0] a, bit with_adv = 0);
    proc_strobe = p; ctrl_strobe = c; cs_block = cs; addr_in = a; adv = with_adv;
    @(negedge clk);
    proc_strobe = 0; ctrl_strobe = 0; cs_block = 0; adv = 0;
  endtask

  task automatic step_beat();
    adv = 1; @(negedge clk); adv = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; idle(2); rst = 0;
    chk("R1 valid", beat_valid, 0);
    chk("R1 beat", beat_addr, 0);
    chk("R1 line", line_addr, 0);
    chk("R1 src", start_src, 0);
    adv = 1; idle(3); adv = 0;
    chk("R11 beat", beat_addr, 0);
    chk("R11 valid", beat_valid, 0);
  endtask

  task automatic t_burst(bit il, logic [ADDR_W-1:0] a, bit holds);
    interleave_mode = il;
    load(1, 0, 0, a);
    chk("R2 line", line_addr, a[ADDR_W-1:2]);
    chk("R2 beat", beat_addr, a[1:0]);
    chk("R2 valid", beat_valid, 1);
    chk("R2 src", start_src, 0);
    for (int k = 1; k <= 4; k++) begin
      if (holds) begin
        idle(2);
        chk("R8 hold", beat_addr, expect_beat(a[1:0], k - 1, il));
      end
      step_beat();
      chk(il ? "R7 beat" : "R6 beat", beat_addr, expect_beat(a[1:0], k % 4, il));
    end
    chk("R9 wrap beat", beat_addr, a[1:0]);
    chk("R9 line", line_addr, a[ADDR_W-1:2]);
  endtask

  task automatic t_strobes();
    interleave_mode = 0;
    load(0, 1, 1, 18'h2AB5D);
    chk("R3 line", line_addr, 18'h2AB5D >> 2);
    chk("R3 beat", beat_addr, 1);
    chk("R3 src", start_src, 1);
    load(1, 0, 1, 18'h01234);
    chk("R4 line", line_addr, 18'h2AB5D >> 2);
    chk("R4 beat", beat_addr, 1);
    chk("R4 src", start_src, 1);
    load(1, 1, 0, 18'h3F00E);
    chk("R5 src", start_src, 0);
    chk("R5 line", line_addr, 18'h3F00E >> 2);
    load(1, 1, 1, 18'h10003);
    chk("R3 masked proc src", start_src, 1);
    chk("R3 masked proc beat", beat_addr, 3);
  endtask

  task automatic t_restart();
    interleave_mode = 1;
    load(1, 0, 0, 18'h00442);
    step_beat();
    chk("R7 first", beat_addr, 3);
    load(0, 1, 0, 18'h00881, 1);
    chk("R10 beat", beat_addr, 1);
    chk("R10 line", line_addr, 18'h00881 >> 2);
    step_beat();
    chk("R10 next", beat_addr, 0);
  endtask

  initial begin
    rst = 1; proc_strobe = 0; ctrl_strobe = 0; cs_block = 0; adv = 0;
    interleave_mode = 0; addr_in = '0;
    @(negedge clk);
    t_reset();
    t_burst(0, 18'h12346, 0);
    t_burst(0, 18'h3FFFF, 1);
    t_burst(1, 18'h0ABC5, 0);
    t_burst(1, 18'h2000A, 1);
    t_strobes();
    t_restart();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual 0 expected 1");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule